// File: doc/BRIEF.md
# Branch Delay-Slot Quash Controller

This controller sits beside the issue and commit stages of a pipeline that issues two instructions per cycle. When a branch issues, the controller takes two cycles to resolve it. During that time the next two instruction bundles issue behind the branch. These are the delay slots. Each branch carries a two-bit quash rule, which says whether those two bundles may write their results: always, only when the branch test is true, or only when it is false.

The condition result is sampled once, in the cycle after the branch issues. The verdict for each delay bundle is applied as that bundle passes through commit, one cycle after its issue. A squashed bundle keeps its pipeline slot, but its register-file and memory write enables are forced low on every lane. When the branch is taken, the controller presents the target to fetch in the cycle the first delay bundle commits. When the branch is not taken, fetch simply continues in sequence.

The controller never stalls. Scheduling around delay-slot hazards is left to software. A branch that issues inside the delay slots of an unresolved branch is flagged and otherwise dropped.

Top module: `bq_ctrl`

## Requirements
- R1: When a branch is accepted in cycle T, `dslot_o` reads 2'b01 in cycle T+2 (first delay bundle at commit) and 2'b10 in cycle T+3 (second delay bundle). Otherwise it reads 2'b00.
- R2: Quash rule 2'b00 lets both delay bundles commit, whatever the condition.
- R3: Quash rule 2'b01 commits both delay bundles only if `br_cond_i` is 1 in cycle T+1. Otherwise it squashes both.
- R4: Quash rule 2'b10 commits both delay bundles only if `br_cond_i` is 0 in cycle T+1. Otherwise it squashes both.
- R5: Quash rule 2'b11 behaves exactly like 2'b00.
- R6: While `squash_o` is 1, `rf_we_o` and `mem_we_o` are all zero on every lane. At all other times they equal `rf_we_i` and `mem_we_i`. `squash_o` is 1 only during delay-bundle commit cycles.
- R7: When `br_cond_i` is 1 in T+1, `redir_vld_o` is 1 in T+2 with `redir_addr_o` equal to the target captured in T. When the condition is 0, no redirect is issued. `redir_vld_o` is 0 in every other cycle.
- R8: A branch presented in T+1 or T+2 raises `nest_err_o` in that same cycle and has no other effect: it changes no verdict, issues no redirect and starts no delay sequence.
- R9: A branch presented while no branch is unresolved, including in T+3, is accepted with `nest_err_o` low. The block has no stall output.
- R10: Reset is synchronous and active high. It clears any pending branch, and `squash_o` is 0 in every cycle with reset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| br_valid_i | input | 1 | A branch is in the issuing bundle |
| br_mode_i | input | 2 | Quash rule of the issuing branch |
| br_target_i | input | AW | Target address of the issuing branch |
| br_cond_i | input | 1 | Branch test result, sampled in the cycle after issue |
| rf_we_i | input | LANES | Register write enables of the bundle at commit |
| mem_we_i | input | LANES | Memory write enables of the bundle at commit |
| rf_we_o | output | LANES | Gated register write enables |
| mem_we_o | output | LANES | Gated memory write enables |
| squash_o | output | 1 | The bundle at commit is squashed |
| dslot_o | output | 2 | Which delay bundle is at commit (one-hot) |
| redir_vld_o | output | 1 | Fetch redirect strobe |
| redir_addr_o | output | AW | Redirect address, zero when no strobe |
| nest_err_o | output | 1 | Branch seen inside unresolved delay slots |

## Verification
Several properties are checked on every cycle. The first delay slot is always followed by the second. Squash always clears every write enable, and squash appears only in delay slots. The verdict does not change between the two delay bundles. The redirect lines up with the first delay slot. Each quash rule matches the mode and condition seen two and one cycles earlier.

Other behaviour needs the bench's scenarios. These include the exact redirect address, that a nested branch truly starts no extra sequence, that a branch is accepted back-to-back in T+3, and that reset in the middle of a sequence removes the pending redirect.

// File: rtl/bq_pkg.sv
package bq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RES   = 2'd1,
    ST_SLOT2 = 2'd2,
    ST_TAIL  = 2'd3
  } bq_state_e;

  localparam logic [1:0] QM_ALWAYS   = 2'b00;
  localparam logic [1:0] QM_IF_TRUE  = 2'b01;
  localparam logic [1:0] QM_IF_FALSE = 2'b10;

  // Returns 1 when the delay bundles may keep their results.
  function automatic logic bq_keep(input logic [1:0] mode, input logic cond);
    case (mode)
      QM_IF_TRUE:  return cond;
      QM_IF_FALSE: return !cond;
      default:     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bq_seq.sv
module bq_seq
  import bq_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          br_valid_i,
  input  logic [1:0]    br_mode_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          br_cond_i,
  output logic          busy_o,
  output logic          slot1_o,
  output logic          slot2_o,
  output logic          verdict_sq_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_addr_o
);

  bq_state_e     state_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] target_q;
  logic          taken_q;
  logic          sq_q;
  logic          accept;

  assign busy_o = (state_q == ST_RES) || (state_q == ST_SLOT2);
  assign accept = br_valid_i && !busy_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      mode_q   <= QM_ALWAYS;
      target_q <= '0;
      taken_q  <= 1'b0;
      sq_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_RES: begin
          taken_q <= br_cond_i;
          sq_q    <= !bq_keep(mode_q, br_cond_i);
          state_q <= ST_SLOT2;
        end
        ST_SLOT2: state_q <= ST_TAIL;
        default: begin
          if (accept) begin
            state_q  <= ST_RES;
            mode_q   <= br_mode_i;
            target_q <= br_target_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign slot1_o      = (state_q == ST_SLOT2);
  assign slot2_o      = (state_q == ST_TAIL);
  assign verdict_sq_o = sq_q;
  assign redir_vld_o  = slot1_o && taken_q;
  assign redir_addr_o = redir_vld_o ? target_q : '0;

endmodule

// File: rtl/bq_gate.sv
module bq_gate #(
  parameter int LANES = 2
) (
  input  logic             squash_i,
  input  logic [LANES-1:0] rf_we_i,
  input  logic [LANES-1:0] mem_we_i,
  output logic [LANES-1:0] rf_we_o,
  output logic [LANES-1:0] mem_we_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rf_we_o[g]  = rf_we_i[g]  && !squash_i;
    assign mem_we_o[g] = mem_we_i[g] && !squash_i;
  end

endmodule

// File: rtl/bq_ctrl.sv
module bq_ctrl #(
  parameter int AW    = 40,
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             br_valid_i,
  input  logic [1:0]       br_mode_i,
  input  logic [AW-1:0]    br_target_i,
  input  logic             br_cond_i,
  input  logic [LANES-1:0] rf_we_i,
  input  logic [LANES-1:0] mem_we_i,
  output logic [LANES-1:0] rf_we_o,
  output logic [LANES-1:0] mem_we_o,
  output logic             squash_o,
  output logic [1:0]       dslot_o,
  output logic             redir_vld_o,
  output logic [AW-1:0]    redir_addr_o,
  output logic             nest_err_o
);

  logic busy;
  logic slot1;
  logic slot2;
  logic verdict_sq;
  logic in_slot;

  bq_seq #(.AW(AW)) u_seq (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .br_valid_i   (br_valid_i),
    .br_mode_i    (br_mode_i),
    .br_target_i  (br_target_i),
    .br_cond_i    (br_cond_i),
    .busy_o       (busy),
    .slot1_o      (slot1),
    .slot2_o      (slot2),
    .verdict_sq_o (verdict_sq),
    .redir_vld_o  (redir_vld_o),
    .redir_addr_o (redir_addr_o)
  );

  assign in_slot    = slot1 || slot2;
  assign squash_o   = verdict_sq && in_slot && !rst_i;
  assign dslot_o    = {slot2, slot1};
  assign nest_err_o = br_valid_i && busy;

  bq_gate #(.LANES(LANES)) u_gate (
    .squash_i (squash_o),
    .rf_we_i  (rf_we_i),
    .mem_we_i (mem_we_i),
    .rf_we_o  (rf_we_o),
    .mem_we_o (mem_we_o)
  );

endmodule

// File: rtl/bq_ctrl_chk.sv
module bq_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             br_valid_i,
  input logic [1:0]       br_mode_i,
  input logic             br_cond_i,
  input logic [LANES-1:0] rf_we_i,
  input logic [LANES-1:0] mem_we_i,
  input logic [LANES-1:0] rf_we_o,
  input logic [LANES-1:0] mem_we_o,
  input logic             squash_o,
  input logic [1:0]       dslot_o,
  input logic             redir_vld_o,
  input logic             nest_err_o
);

  AST_DSLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(dslot_o)); // R1
  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
    dslot_o[0] |=> dslot_o[1]); // R1
  AST_MODE_ALWAYS: assert property (@(posedge clk_i) disable iff (rst_i)
    (dslot_o[0] && ($past(br_mode_i, 2) == 2'b00)) |-> !squash_o); // R2
  AST_MODE_IF_TRUE: assert property (@(posedge clk_i) disable iff (rst_i)
    (dslot_o[0] && ($past(br_mode_i, 2) == 2'b01)) |-> (squash_o == !$past(br_cond_i))); // R3
  AST_MODE_IF_FALSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (dslot_o[0] && ($past(br_mode_i, 2) == 2'b10)) |-> (squash_o == $past(br_cond_i))); // R4
  AST_MODE_SPARE: assert property (@(posedge clk_i) disable iff (rst_i)
    (dslot_o[0] && ($past(br_mode_i, 2) == 2'b11)) |-> !squash_o); // R5
  AST_VERDICT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    dslot_o[0] |=> $stable(squash_o)); // R2
  AST_SQUASH_GATES: assert property (@(posedge clk_i) disable iff (rst_i)
    squash_o |-> ((rf_we_o == '0) && (mem_we_o == '0))); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (rst_i)
    !squash_o |-> ((rf_we_o == rf_we_i) && (mem_we_o == mem_we_i))); // R6
  AST_SQUASH_IN_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    squash_o |-> (dslot_o != 2'b00)); // R6
  AST_REDIR_ALIGN: assert property (@(posedge clk_i) disable iff (rst_i)
    redir_vld_o |-> dslot_o[0]); // R7
  AST_ERR_NEEDS_BR: assert property (@(posedge clk_i) disable iff (rst_i)
    nest_err_o |-> br_valid_i); // R8
  AST_RESET_NO_SQ: assert property (@(posedge clk_i)
    rst_i |-> !squash_o); // R10

endmodule

bind bq_ctrl bq_ctrl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_bq_ctrl.sv
module tb_bq_ctrl;

  localparam int AW    = 40;
  localparam int LANES = 2;

  logic             clk = 1'b0;
  logic             rst_i;
  logic             br_valid_i;
  logic [1:0]       br_mode_i;
  logic [AW-1:0]    br_target_i;
  logic             br_cond_i;
  logic [LANES-1:0] rf_we_i;
  logic [LANES-1:0] mem_we_i;
  logic [LANES-1:0] rf_we_o;
  logic [LANES-1:0] mem_we_o;
  logic             squash_o;
  logic [1:0]       dslot_o;
  logic             redir_vld_o;
  logic [AW-1:0]    redir_addr_o;
  logic             nest_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bq_ctrl #(.AW(AW), .LANES(LANES)) dut (
    .clk_i(clk), .rst_i(rst_i), .br_valid_i(br_valid_i), .br_mode_i(br_mode_i),
    .br_target_i(br_target_i), .br_cond_i(br_cond_i), .rf_we_i(rf_we_i),
    .mem_we_i(mem_we_i), .rf_we_o(rf_we_o), .mem_we_o(mem_we_o),
    .squash_o(squash_o), .dslot_o(dslot_o), .redir_vld_o(redir_vld_o),
    .redir_addr_o(redir_addr_o), .nest_err_o(nest_err_o)
  );

  // {mode[1:0], cond, nested-branch-in-T+1}
  localparam logic [3:0] VEC [10] = '{
    4'b00_0_0, 4'b00_1_1, 4'b01_1_0, 4'b01_0_0, 4'b10_0_1,
    4'b10_1_0, 4'b11_0_0, 4'b11_1_1, 4'b01_1_1, 4'b10_0_0
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_squash(input logic [1:0] m, input logic c);
    if (m == 2'b01) return !c;
    if (m == 2'b10) return c;
    return 1'b0;
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_i = 1'b1; br_valid_i = 1'b0; br_mode_i = 2'b00; br_target_i = '0;
    br_cond_i = 1'b0; rf_we_i = 2'b11; mem_we_i = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    chk(squash_o == 1'b0, "R10 squash in reset", 64'(squash_o), 0);
    chk(dslot_o == 2'b00, "R10 dslot after reset edge", 64'(dslot_o), 0);
    @(negedge clk); rst_i = 1'b0;
    #1;
    chk(redir_vld_o == 1'b0, "R10 no redirect after reset", 64'(redir_vld_o), 0);
    chk(rf_we_o == 2'b11, "R6 pass-through idle", 64'(rf_we_o), 64'h3);

    for (int v = 0; v < 10; v++) begin
      logic [1:0]    m;
      logic          c, nest, sq;
      logic [AW-1:0] tgt;
      logic [1:0]    rfp, mmp;
      m = VEC[v][3:2]; c = VEC[v][1]; nest = VEC[v][0];
      sq = exp_squash(m, c);
      tgt = AW'(40'h80_0000_0100 + 40'(v * 64));
      rfp = 2'(v + 1); mmp = 2'(~v);
      // cycle T
      @(negedge clk);
      br_valid_i = 1'b1; br_mode_i = m; br_target_i = tgt; br_cond_i = !c;
      rf_we_i = rfp; mem_we_i = mmp;
      #1 chk(nest_err_o == 1'b0, "R9 accept when idle", 64'(nest_err_o), 0);
      // cycle T+1: condition, optional nested branch
      @(negedge clk);
      br_valid_i = nest; br_mode_i = ~m; br_target_i = ~tgt; br_cond_i = c;
      #1 chk(nest_err_o == nest, "R8 nested flag T+1", 64'(nest_err_o), 64'(nest));
      // cycle T+2: first delay bundle commits
      @(negedge clk);
      br_valid_i = 1'b0; br_cond_i = !c;
      #1;
      chk(dslot_o == 2'b01, "R1 slot1", 64'(dslot_o), 64'h1);
      chk(squash_o == sq, {mode_req(m), " verdict slot1"}, 64'(squash_o), 64'(sq));
      chk(rf_we_o == (sq ? 2'b00 : rfp), "R6 rf gate slot1", 64'(rf_we_o), 64'(sq ? 2'b00 : rfp));
      chk(mem_we_o == (sq ? 2'b00 : mmp), "R6 mem gate slot1", 64'(mem_we_o), 64'(sq ? 2'b00 : mmp));
      chk(redir_vld_o == c, "R7 redirect strobe", 64'(redir_vld_o), 64'(c));
      if (c) chk(redir_addr_o == tgt, "R7 redirect addr", 64'(redir_addr_o), 64'(tgt));
      // cycle T+3: second delay bundle commits
      @(negedge clk);
      #1;
      chk(dslot_o == 2'b10, "R1 slot2", 64'(dslot_o), 64'h2);
      chk(squash_o == sq, {mode_req(m), " verdict slot2"}, 64'(squash_o), 64'(sq));
      chk(rf_we_o == (sq ? 2'b00 : rfp), "R6 rf gate slot2", 64'(rf_we_o), 64'(sq ? 2'b00 : rfp));
      chk(redir_vld_o == 1'b0, "R7 single redirect", 64'(redir_vld_o), 0);
      // cycle T+4: sequence over, nested branch left no trace
      @(negedge clk);
      #1;
      chk(dslot_o == 2'b00, "R8 no extra sequence", 64'(dslot_o), 0);
      chk(squash_o == 1'b0, "R6 no squash outside slots", 64'(squash_o), 0);
      chk(rf_we_o == rfp, "R6 pass-through after", 64'(rf_we_o), 64'(rfp));
      chk(redir_vld_o == 1'b0, "R8 no redirect from nested", 64'(redir_vld_o), 0);
    end

    // Nested branch in T+2, then back-to-back branch in T+3
    rf_we_i = 2'b11; mem_we_i = 2'b11;
    @(negedge clk);
    br_valid_i = 1'b1; br_mode_i = 2'b01; br_target_i = 40'h11_2233_4450;
    @(negedge clk);
    br_valid_i = 1'b0; br_cond_i = 1'b0;
    @(negedge clk);
    br_valid_i = 1'b1; br_mode_i = 2'b10; br_target_i = 40'h00_dead_0000;
    #1 chk(nest_err_o == 1'b1, "R8 nested flag T+2", 64'(nest_err_o), 1);
    chk(squash_o == 1'b1, "R3 squash on false", 64'(squash_o), 1);
    @(negedge clk);
    br_valid_i = 1'b1; br_mode_i = 2'b00; br_target_i = 40'h55_0000_0aa0;
    #1 chk(nest_err_o == 1'b0, "R9 back-to-back accept", 64'(nest_err_o), 0);
    chk(squash_o == 1'b1, "R3 slot2 squash kept", 64'(squash_o), 1);
    @(negedge clk);
    br_valid_i = 1'b0; br_cond_i = 1'b1;
    #1 chk(dslot_o == 2'b00, "R9 no stall gap", 64'(dslot_o), 0);
    @(negedge clk);
    br_cond_i = 1'b0;
    #1 chk(dslot_o == 2'b01, "R9 new branch slot1", 64'(dslot_o), 1);
    chk(squash_o == 1'b0, "R2 always keep", 64'(squash_o), 0);
    chk(redir_addr_o == 40'h55_0000_0aa0, "R9 new target", 64'(redir_addr_o), 64'h5500000aa0);

    // Reset in the middle of a sequence
    @(negedge clk);
    @(negedge clk);
    br_valid_i = 1'b1; br_mode_i = 2'b01; br_target_i = 40'h77_0000_0000;
    @(negedge clk);
    br_valid_i = 1'b0; br_cond_i = 1'b1; rst_i = 1'b1;
    #1 chk(squash_o == 1'b0, "R10 squash low in reset", 64'(squash_o), 0);
    @(negedge clk);
    rst_i = 1'b0;
    #1 chk(dslot_o == 2'b00, "R10 pending cleared", 64'(dslot_o), 0);
    chk(redir_vld_o == 1'b0, "R10 redirect dropped", 64'(redir_vld_o), 0);
    @(negedge clk);
    #1 chk(dslot_o == 2'b00, "R10 still idle", 64'(dslot_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule